// File: doc/BRIEF.md
# Read/Write Bus Turnaround Controller

This block owns the direction of a memory controller's shared data bus. Every cycle it looks at how many reads and writes are waiting, counts the commands the scheduler actually issues, and decides whether the bus keeps serving its current direction or starts turning around. A switch always passes through a dedicated turnaround state. While the block is in that state no command may be issued, and it stays there for a programmable number of cycles.

Reads are the default direction. Writes build up until the write backlog crosses a programmable high mark, or until no reads are left to serve. The block then drains writes. It keeps draining until a programmable minimum number of writes has gone out in this phase. After that it returns to reads once the write backlog has dropped to a programmable low mark, or once reads are waiting. If the write backlog empties, draining ends at once. The scheduler that picks the next request reads the direction and the issue-allowed flag. It reports each issued read or write on a strobe.

Top module: `bus_turnaround`

## Requirements
- R1: After reset `bus_dir` is 0 (READ), `issue_ok` is 1, and both phase counters are 0.
- R2: `bus_dir` encodes 0 = READ, 1 = read-to-write turnaround, 2 = WRITE, 3 = write-to-read turnaround. It only ever changes to the next value in the cycle 0, 1, 2, 3, 0.
- R3: In READ, if `wr_q_cnt > wr_hi_mark`, or if `rd_q_cnt == 0` and `wr_q_cnt != 0`, the next cycle is read-to-write turnaround. Otherwise the block stays in READ.
- R4: While `wr_q_cnt` is 0, the block never leaves READ, whatever the read backlog and the strobes are.
- R5: The read-to-write turnaround lasts `t_rtw + 1` cycles and then enters WRITE. The write-to-read turnaround lasts `t_wtr + 1` cycles and then enters READ. The turnaround value is taken when the state is entered.
- R6: In WRITE, the next cycle is write-to-read turnaround if `wr_q_cnt == 0`. It is also write-to-read turnaround if `wr_phase_cnt >= min_wr_burst` and either `wr_q_cnt <= wr_lo_mark` or `rd_q_cnt != 0`. Otherwise the block stays in WRITE.
- R7: `issue_ok` is 1 in READ and WRITE and 0 in both turnaround states.
- R8: `rd_phase_cnt` clears when READ is entered. It then adds one for each cycle in READ with `rd_issue` high. `wr_phase_cnt` behaves the same way for WRITE and `wr_issue`. A strobe given in any other state leaves the counters unchanged. Both counters saturate at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_q_cnt | input | QW | Reads waiting |
| wr_q_cnt | input | QW | Writes waiting |
| rd_issue | input | 1 | A read was issued this cycle |
| wr_issue | input | 1 | A write was issued this cycle |
| wr_hi_mark | input | QW | Write backlog that forces draining when exceeded |
| wr_lo_mark | input | QW | Write backlog at or below which draining may stop |
| min_wr_burst | input | CW | Writes required before a drain may end early |
| t_rtw | input | TW | Extra cycles of read-to-write turnaround |
| t_wtr | input | TW | Extra cycles of write-to-read turnaround |
| bus_dir | output | 2 | Current bus state (encoding in R2) |
| issue_ok | output | 1 | A command may be issued this cycle |
| rd_phase_cnt | output | CW | Reads issued in the current read phase |
| wr_phase_cnt | output | CW | Writes issued in the current write phase |

## Verification
The bench sweeps every combination of two high marks, two low marks, two minimum burst sizes and three values each for both turnaround lengths. Under each combination it drives random backlogs and random issue strobes, including strobes during turnaround. It compares the state, the flag and both counters against an arithmetic model every cycle. The small minimum burst separates the exit on low mark from the exit on pending reads, because both conditions are often true together. The larger minimum burst shows that neither condition can end a drain early, while an empty write backlog still does. A leading stretch with an empty write backlog and reads waiting tells apart a policy that enters WRITE with nothing to write.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    BT_READ  = 2'd0,
    BT_RD2WR = 2'd1,
    BT_WRITE = 2'd2,
    BT_WR2RD = 2'd3
  } bt_dir_e;
endpackage

// File: rtl/bt_timer.sv
module bt_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bt_phase_cnt.sv
module bt_phase_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear || (inc && (count != CMAX));
    cnt_d  = clear ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end
endmodule

// File: rtl/bt_policy.sv
module bt_policy
  import bt_pkg::*;
#(
  parameter int QW = 6,
  parameter int CW = 8
) (
  input  bt_dir_e       cur,
  input  logic [QW-1:0] rd_q,
  input  logic [QW-1:0] wr_q,
  input  logic [QW-1:0] hi_mark,
  input  logic [QW-1:0] lo_mark,
  input  logic [CW-1:0] min_wr,
  input  logic [CW-1:0] wr_done,
  input  logic          tmr_expired,
  output bt_dir_e       nxt
);
  logic rd_pend, wr_pend, wr_over, wr_under, burst_met;
  logic go_write, stop_write;

  always_comb begin
    rd_pend    = (rd_q != '0);
    wr_pend    = (wr_q != '0);
    wr_over    = (wr_q > hi_mark);
    wr_under   = (wr_q <= lo_mark);
    burst_met  = (wr_done >= min_wr);
    go_write   = wr_pend && (wr_over || !rd_pend);
    stop_write = !wr_pend || (burst_met && (wr_under || rd_pend));
  end

  always_comb begin
    nxt = cur;
    unique case (cur)
      BT_READ:  if (go_write)    nxt = BT_RD2WR;
      BT_RD2WR: if (tmr_expired) nxt = BT_WRITE;
      BT_WRITE: if (stop_write)  nxt = BT_WR2RD;
      BT_WR2RD: if (tmr_expired) nxt = BT_READ;
      default:                   nxt = BT_READ;
    endcase
  end
endmodule

// File: rtl/bus_turnaround.sv
module bus_turnaround
  import bt_pkg::*;
#(
  parameter int QW = 6,
  parameter int CW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] rd_q_cnt,
  input  logic [QW-1:0] wr_q_cnt,
  input  logic          rd_issue,
  input  logic          wr_issue,
  input  logic [QW-1:0] wr_hi_mark,
  input  logic [QW-1:0] wr_lo_mark,
  input  logic [CW-1:0] min_wr_burst,
  input  logic [TW-1:0] t_rtw,
  input  logic [TW-1:0] t_wtr,
  output logic [1:0]    bus_dir,
  output logic          issue_ok,
  output logic [CW-1:0] rd_phase_cnt,
  output logic [CW-1:0] wr_phase_cnt
);
  localparam int NDIR = 2;

  bt_dir_e       st_q, st_d;
  logic          tmr_expired, tmr_load;
  logic [TW-1:0] tmr_val;
  logic [CW-1:0] phase_cnt [NDIR];

  bt_policy #(.QW(QW), .CW(CW)) u_policy (
    .cur         (st_q),
    .rd_q        (rd_q_cnt),
    .wr_q        (wr_q_cnt),
    .hi_mark     (wr_hi_mark),
    .lo_mark     (wr_lo_mark),
    .min_wr      (min_wr_burst),
    .wr_done     (phase_cnt[1]),
    .tmr_expired (tmr_expired),
    .nxt         (st_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BT_READ;
    else        st_q <= st_d;
  end

  always_comb begin
    tmr_load = (st_d != st_q) && st_d[0];
    tmr_val  = (st_d == BT_RD2WR) ? t_rtw : t_wtr;
  end

  bt_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  for (genvar g = 0; g < NDIR; g++) begin : g_phase
    localparam bt_dir_e DIR = (g == 0) ? BT_READ : BT_WRITE;
    logic strobe;
    assign strobe = (g == 0) ? rd_issue : wr_issue;
    bt_phase_cnt #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear ((st_d == DIR) && (st_q != DIR)),
      .inc   (strobe && (st_q == DIR)),
      .count (phase_cnt[g])
    );
  end

  assign bus_dir      = st_q;
  assign issue_ok     = ~st_q[0];
  assign rd_phase_cnt = phase_cnt[0];
  assign wr_phase_cnt = phase_cnt[1];
endmodule

// File: rtl/bt_chk.sv
module bt_chk #(
  parameter int QW = 6,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [QW-1:0] rd_q_cnt,
  input logic [QW-1:0] wr_q_cnt,
  input logic [QW-1:0] wr_hi_mark,
  input logic [1:0]    bus_dir,
  input logic          issue_ok,
  input logic [CW-1:0] rd_phase_cnt,
  input logic [CW-1:0] wr_phase_cnt
);
  p_turn_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dir[0] |-> !issue_ok);

  p_cyclic_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir != $past(bus_dir)) |-> (bus_dir == 2'($past(bus_dir) + 2'd1)));

  p_hi_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir == 2'd0 && wr_q_cnt > wr_hi_mark) |=> (bus_dir == 2'd1));

  p_empty_wr_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir == 2'd0 && wr_q_cnt == '0) |=> (bus_dir == 2'd0));

  p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir == 2'd0 && $past(bus_dir) == 2'd3) |-> (rd_phase_cnt == '0));

  p_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir == 2'd2 && $past(bus_dir) == 2'd1) |-> (wr_phase_cnt == '0));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir == 2'd1 || bus_dir == 2'd2) |=> $stable(rd_phase_cnt));

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir == 2'd3 || bus_dir == 2'd0) && !(bus_dir == 2'd0 && rd_q_cnt == '0 && wr_q_cnt != '0)
      && !(bus_dir == 2'd0 && wr_q_cnt > wr_hi_mark) |=> $stable(wr_phase_cnt));
endmodule

bind bus_turnaround bt_chk #(.QW(QW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_q_cnt     (rd_q_cnt),
  .wr_q_cnt     (wr_q_cnt),
  .wr_hi_mark   (wr_hi_mark),
  .bus_dir      (bus_dir),
  .issue_ok     (issue_ok),
  .rd_phase_cnt (rd_phase_cnt),
  .wr_phase_cnt (wr_phase_cnt)
);

// File: tb/sim_bus_turnaround.sv
module sim_bus_turnaround;
  localparam int QW = 6, CW = 8, TW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [QW-1:0] rd_q_cnt, wr_q_cnt, wr_hi_mark, wr_lo_mark;
  logic [CW-1:0] min_wr_burst;
  logic [TW-1:0] t_rtw, t_wtr;
  logic rd_issue, wr_issue;
  logic [1:0] bus_dir;
  logic issue_ok;
  logic [CW-1:0] rd_phase_cnt, wr_phase_cnt;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_st, m_tmr, m_rc, m_wc;

  always #2 clk = ~clk;

  bus_turnaround #(.QW(QW), .CW(CW), .TW(TW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(bus_dir == 2'(m_st), "R2 R3 R5 R6 state", int'(bus_dir), m_st);
    chk(issue_ok == (m_st == 0 || m_st == 2), "R7 issue_ok", int'(issue_ok),
        int'(m_st == 0 || m_st == 2));
    chk(rd_phase_cnt == CW'(m_rc), "R8 rd count", int'(rd_phase_cnt), m_rc);
    chk(wr_phase_cnt == CW'(m_wc), "R8 wr count", int'(wr_phase_cnt), m_wc);
  endtask

  // Arithmetic model of one clock edge using the inputs now applied
  task automatic model_step();
    int rq = int'(rd_q_cnt), wq = int'(wr_q_cnt);
    int nst = m_st;
    case (m_st)
      0: if (wq != 0 && (wq > int'(wr_hi_mark) || rq == 0)) nst = 1;
      1: if (m_tmr == 0) nst = 2;
      2: if (wq == 0 || (m_wc >= int'(min_wr_burst) &&
                         (wq <= int'(wr_lo_mark) || rq != 0))) nst = 3;
      default: if (m_tmr == 0) nst = 0;
    endcase
    if (nst == 1 && m_st != 1)      m_tmr = int'(t_rtw);
    else if (nst == 3 && m_st != 3) m_tmr = int'(t_wtr);
    else if (m_tmr != 0)            m_tmr--;
    if (nst == 0 && m_st != 0)                  m_rc = 0;
    else if (m_st == 0 && rd_issue && m_rc < CMAX) m_rc++;
    if (nst == 2 && m_st != 2)                  m_wc = 0;
    else if (m_st == 2 && wr_issue && m_wc < CMAX) m_wc++;
    m_st = nst;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rd_q_cnt = '0; wr_q_cnt = '0; rd_issue = 0; wr_issue = 0;
    m_st = 0; m_tmr = 0; m_rc = 0; m_wc = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(bus_dir == 2'd0, "R1 dir", int'(bus_dir), 0);
    chk(issue_ok == 1'b1, "R1 issue_ok", int'(issue_ok), 1);
    chk(rd_phase_cnt == '0 && wr_phase_cnt == '0, "R1 counters",
        int'(rd_phase_cnt) + int'(wr_phase_cnt), 0);
  endtask

  initial begin
    int hi_v [2] = '{2, 5};
    int lo_v [2] = '{0, 1};
    int mn_v [2] = '{1, 3};
    void'($urandom(11));
    for (int h = 0; h < 2; h++)
      for (int l = 0; l < 2; l++)
        for (int m = 0; m < 2; m++)
          for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++) begin
              wr_hi_mark = QW'(hi_v[h]); wr_lo_mark = QW'(lo_v[l]);
              min_wr_burst = CW'(mn_v[m]); t_rtw = TW'(a); t_wtr = TW'(b);
              do_reset();
              // R4: empty write backlog with reads waiting keeps READ
              for (int c = 0; c < 12; c++) begin
                rd_q_cnt = QW'($urandom_range(1, 3)); wr_q_cnt = '0;
                rd_issue = 1'($urandom); wr_issue = 1'($urandom);
                model_step();
                @(negedge clk);
                chk(bus_dir == 2'd0, "R4 stays READ", int'(bus_dir), 0);
                cmp_all();
              end
              // Random backlogs and strobes, including strobes in turnaround
              for (int c = 0; c < 70; c++) begin
                rd_q_cnt = ($urandom_range(0, 3) == 0) ? '0 : QW'($urandom_range(1, 3));
                wr_q_cnt = QW'($urandom_range(0, 7));
                rd_issue = 1'($urandom); wr_issue = 1'($urandom);
                model_step();
                @(negedge clk);
                cmp_all();
              end
            end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule